// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running calendar, supplied in BCD on input buses by a separate time-keeping block, and raises an alarm flag when the calendar reaches a programmed alarm word. The comparison happens only when the one-second `tick` pulses. The alarm word covers four fields: seconds, minutes, hours with a PM bit, and a day field. Each field has its own don't-care bit. A selector bit makes the day field compare against either the weekday or the day of the month. Month and year have no inputs, so they never take part in the comparison.

Software arms the comparator with an enable bit and routes the flag to an interrupt with a separate interrupt-enable bit. The alarm word is protected by a handshake. Once the enable has been cleared, a write-allowed flag rises after a parameterised number of slow-clock enable pulses. Writes to the alarm word are accepted only while that flag is high. The alarm flag is sticky. It sets on the first tick on which the calendar matches and stays set until software clears it.

Top module: `cal_alarm_unit`

## Requirements
- R1: Alarm word layout, with these bit positions relied on. Seconds BCD is in 6:0 and minutes BCD in 14:8. Hours BCD is in 21:16 and the PM bit in 22. The day is in 29:24, or in 27:24 in weekday mode. An unmasked field matches only when it equals the calendar input, and the hours field is compared together with the PM bit.
- R2: Bits 7, 31, 15 and 23 are don't-care bits for seconds, the day, minutes and hours respectively. A set don't-care bit removes that field from the comparison.
- R3: When bit 30 is set, bits 27:24 are compared with the weekday input (1..7) and the day-of-month input is ignored. When bit 30 is clear, bits 29:24 are compared with the BCD day of month and the weekday input is ignored.
- R4: While the alarm enable is low, no tick sets the alarm flag.
- R5: The write-allowed flag is low in the cycle after the enable is written to 1, and it stays low while the enable is high. After the enable is cleared, the flag rises on the WA_DELAY-th `slow_en` pulse (default 2) and not before. After reset it is low, and it then follows the same delay rule.
- R6: A write to the alarm word takes effect one cycle later when the write-allowed flag is high. While the flag is low, the write is ignored and the word read back is unchanged.
- R7: The alarm flag sets one cycle after a tick that finds a match, only when the previous tick did not match. A match that holds across consecutive ticks does not set it again.
- R8: The alarm flag stays set until `flag_clr` clears it, one cycle later. When a set and a clear fall in the same cycle, the set wins.
- R9: `irq` is high exactly when both the alarm flag and the interrupt enable are high.
- R10: After reset the alarm word is 0, and the enable, interrupt enable, write-allowed flag, alarm flag and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse per second; the comparison happens on it |
| slow_en | input | 1 | One pulse per slow-clock cycle, used for the write-allowed delay |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD |
| cal_pm | input | 1 | Calendar PM indicator |
| cal_mday | input | 6 | Calendar day of month, BCD |
| cal_wday | input | 3 | Calendar weekday, 1..7 |
| ctl_we | input | 1 | Control write strobe |
| ctl_en_d | input | 1 | Alarm enable value written by ctl_we |
| ctl_ie_d | input | 1 | Interrupt enable value written by ctl_we |
| alm_we | input | 1 | Alarm word write strobe |
| alm_wdata | input | 32 | Alarm word write data |
| flag_clr | input | 1 | Clears the sticky alarm flag |
| alm_word | output | 32 | Current alarm word |
| alm_en | output | 1 | Alarm enable state |
| irq_en | output | 1 | Interrupt enable state |
| wr_ok | output | 1 | Alarm word write allowed |
| alm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Alarm interrupt |

## Verification
Control writes, alarm-word writes and flag clears take effect one cycle after their strobe. A tick's result shows on `alm_flag` one cycle after the tick, and `wr_ok` rises in the cycle after the qualifying `slow_en` pulse. The bench drives every strobe as a single-cycle pulse between falling edges and reads the outputs at the next falling edge, which comes after the one rising edge that registers the result. The sweep covers all sixteen don't-care combinations in both day modes. For each one, a single field of the calendar is perturbed at a time, and every case begins from a clean edge history, because ticks taken while the comparator is disabled clear the previous-match state.

// File: rtl/cal_alarm_pkg.sv
// Package: shared layout constants for the calendar alarm comparator.
// Assumes a 32-bit alarm word split into four 8-bit lanes, each lane
// holding a 7-bit value with its don't-care bit in the lane's top bit.
package cal_alarm_pkg;
    localparam int unsigned NUM_FIELDS = 4;
    localparam int unsigned LANE_W     = 8;
    localparam int unsigned VAL_W      = LANE_W - 1;
    localparam int unsigned WORD_W     = NUM_FIELDS * LANE_W;
    localparam int unsigned DAY_LANE   = 3;
    localparam int unsigned WDSEL_BIT  = 30;
    localparam int unsigned WDAY_W     = 4;
endpackage

// File: rtl/alarm_ctl_regs.sv
// alarm_ctl_regs: holds the enable and interrupt-enable bits, the
// alarm word, and the write-allowed handshake.
// Assumes slow_en is a single-cycle pulse per slow-clock period.
module alarm_ctl_regs #(
    parameter int unsigned WA_DELAY = 2,
    parameter int unsigned WORD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_en,
    input  logic              ctl_we,
    input  logic              ctl_en_d,
    input  logic              ctl_ie_d,
    input  logic              alm_we,
    input  logic [WORD_W-1:0] alm_wdata,
    output logic              alm_en,
    output logic              irq_en,
    output logic              wr_ok,
    output logic [WORD_W-1:0] alm_word
);
    localparam int unsigned CNT_W = (WA_DELAY < 2) ? 1 : $clog2(WA_DELAY);

    logic             en_nxt;
    logic [CNT_W-1:0] slow_cnt;

    // Next value of the enable, used so the lock drops in the same edge
    assign en_nxt = ctl_we ? ctl_en_d : alm_en;

    // Control bits written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_en <= 1'b0;
            irq_en <= 1'b0;
        end else if (ctl_we) begin
            alm_en <= ctl_en_d;
            irq_en <= ctl_ie_d;
        end
    end

    // Write-allowed handshake: count slow pulses while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_cnt <= '0;
            wr_ok    <= 1'b0;
        end else if (en_nxt) begin
            slow_cnt <= '0;
            wr_ok    <= 1'b0;
        end else if (!wr_ok && slow_en) begin
            if (slow_cnt == CNT_W'(WA_DELAY - 1)) begin
                wr_ok <= 1'b1;
            end else begin
                slow_cnt <= slow_cnt + 1'b1;
            end
        end
    end

    // Alarm word storage, gated by the handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_word <= '0;
        end else if (alm_we && wr_ok) begin
            alm_word <= alm_wdata;
        end
    end

    // R5: an armed comparator never allows word writes
    a_r5_en_locks_word: assert property (@(posedge clk) disable iff (!rst_n)
        alm_en |-> !wr_ok);

    // R5: write permission only appears right after a slow pulse
    a_r5_wr_ok_on_slow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_ok) |-> $past(slow_en));

    // R6: without permission the word holds its value
    a_r6_locked_word: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(alm_word));
endmodule

// File: rtl/alarm_field_match.sv
// alarm_field_match: per-field comparison of the alarm word against the
// calendar. Each lane is compared on its own; its don't-care bit forces a hit.
// Purely combinational; assumes BCD inputs already aligned to lane values.
module alarm_field_match
    import cal_alarm_pkg::*;
(
    input  logic [WORD_W-1:0] alm_word,
    input  logic [6:0]        cal_sec,
    input  logic [6:0]        cal_min,
    input  logic [5:0]        cal_hour,
    input  logic              cal_pm,
    input  logic [5:0]        cal_mday,
    input  logic [2:0]        cal_wday,
    output logic              hit
);
    logic [VAL_W-1:0]      cal_lane [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] lane_hit;
    logic                  wd_mode;

    assign wd_mode = alm_word[WDSEL_BIT];

    // Calendar values laid out like the alarm word lanes
    always_comb begin
        cal_lane[0] = cal_sec;
        cal_lane[1] = cal_min;
        cal_lane[2] = {cal_pm, cal_hour};
        cal_lane[3] = wd_mode ? {4'b0, cal_wday} : {1'b0, cal_mday};
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_lane
        logic [VAL_W-1:0] want;
        if (g == DAY_LANE) begin : g_day
            // Day lane: weekday uses the low nibble only
            assign want = wd_mode
                ? {3'b0, alm_word[g*LANE_W +: WDAY_W]}
                : {1'b0, alm_word[g*LANE_W +: 6]};
        end else begin : g_plain
            assign want = alm_word[g*LANE_W +: VAL_W];
        end
        assign lane_hit[g] = alm_word[g*LANE_W + VAL_W] || (want == cal_lane[g]);
    end

    assign hit = &lane_hit;
endmodule

// File: rtl/alarm_event.sv
// alarm_event: sticky alarm flag with first-match edge detection.
// The previous-tick match is remembered so a held match fires only once.
// Assumes tick is a single-cycle pulse.
module alarm_event (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic alm_en,
    input  logic hit,
    input  logic flag_clr,
    output logic alm_flag
);
    logic last_hit;

    // Track match history and set or clear the sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_hit <= 1'b0;
            alm_flag <= 1'b0;
        end else begin
            if (tick) begin
                last_hit <= hit && alm_en;
            end
            if (tick && alm_en && hit && !last_hit) begin
                alm_flag <= 1'b1;
            end else if (flag_clr) begin
                alm_flag <= 1'b0;
            end
        end
    end

    // R7: the flag only rises after a tick
    a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> $past(tick));

    // R4: the flag only rises while armed
    a_r4_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> $past(alm_en));

    // R8: the flag holds until cleared
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_flag && !flag_clr) |=> alm_flag);
endmodule

// File: rtl/cal_alarm_unit.sv
// cal_alarm_unit: masked calendar alarm comparator, top level.
// Joins the control/handshake registers, the field matcher and the
// sticky event flag; drives the interrupt from flag and interrupt enable.
// Assumes the calendar buses are stable while tick is high.
module cal_alarm_unit
    import cal_alarm_pkg::*;
#(
    parameter int unsigned WA_DELAY = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        slow_en,
    input  logic [6:0]  cal_sec,
    input  logic [6:0]  cal_min,
    input  logic [5:0]  cal_hour,
    input  logic        cal_pm,
    input  logic [5:0]  cal_mday,
    input  logic [2:0]  cal_wday,
    input  logic        ctl_we,
    input  logic        ctl_en_d,
    input  logic        ctl_ie_d,
    input  logic        alm_we,
    input  logic [31:0] alm_wdata,
    input  logic        flag_clr,
    output logic [31:0] alm_word,
    output logic        alm_en,
    output logic        irq_en,
    output logic        wr_ok,
    output logic        alm_flag,
    output logic        irq
);
    logic hit;

    alarm_ctl_regs #(.WA_DELAY(WA_DELAY), .WORD_W(WORD_W)) i_ctl (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en),
        .ctl_we(ctl_we), .ctl_en_d(ctl_en_d), .ctl_ie_d(ctl_ie_d),
        .alm_we(alm_we), .alm_wdata(alm_wdata),
        .alm_en(alm_en), .irq_en(irq_en), .wr_ok(wr_ok), .alm_word(alm_word)
    );

    alarm_field_match i_match (
        .alm_word(alm_word), .cal_sec(cal_sec), .cal_min(cal_min),
        .cal_hour(cal_hour), .cal_pm(cal_pm), .cal_mday(cal_mday),
        .cal_wday(cal_wday), .hit(hit)
    );

    alarm_event i_evt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .alm_en(alm_en),
        .hit(hit), .flag_clr(flag_clr), .alm_flag(alm_flag)
    );

    // Interrupt line: flag qualified by the interrupt enable
    assign irq = alm_flag && irq_en;

    // R2: a word with every don't-care bit set matches any calendar
    a_r2_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_word[7] && alm_word[15] && alm_word[23] && alm_word[31]) |-> hit);

    // R9: no interrupt without the interrupt enable
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

// File: tb/test_cal_alarm_unit.sv
module test_cal_alarm_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, slow_en = 1'b0;
    logic [6:0]  cal_sec = '0, cal_min = '0;
    logic [5:0]  cal_hour = '0, cal_mday = '0;
    logic        cal_pm = 1'b0;
    logic [2:0]  cal_wday = '0;
    logic        ctl_we = 1'b0, ctl_en_d = 1'b0, ctl_ie_d = 1'b0;
    logic        alm_we = 1'b0, flag_clr = 1'b0;
    logic [31:0] alm_wdata = '0;
    logic [31:0] alm_word;
    logic        alm_en, irq_en, wr_ok, alm_flag, irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cal_alarm_unit i_cal_alarm_unit (
        .clk(clk), .rst_n(rst_n), .tick(tick), .slow_en(slow_en),
        .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
        .cal_pm(cal_pm), .cal_mday(cal_mday), .cal_wday(cal_wday),
        .ctl_we(ctl_we), .ctl_en_d(ctl_en_d), .ctl_ie_d(ctl_ie_d),
        .alm_we(alm_we), .alm_wdata(alm_wdata), .flag_clr(flag_clr),
        .alm_word(alm_word), .alm_en(alm_en), .irq_en(irq_en),
        .wr_ok(wr_ok), .alm_flag(alm_flag), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic en, input logic ie);
        @(negedge clk); ctl_we = 1'b1; ctl_en_d = en; ctl_ie_d = ie;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic slow_pulse();
        @(negedge clk); slow_en = 1'b1;
        @(negedge clk); slow_en = 1'b0;
    endtask

    task automatic tick_pulse(input logic clr);
        @(negedge clk); tick = 1'b1; flag_clr = clr;
        @(negedge clk); tick = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic clr_pulse();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic word_write(input logic [31:0] w);
        @(negedge clk); alm_we = 1'b1; alm_wdata = w;
        @(negedge clk); alm_we = 1'b0;
    endtask

    // Disarm and wait for write permission
    task automatic unlock();
        ctl_write(1'b0, 1'b0);
        slow_pulse();
        slow_pulse();
    endtask

    function automatic logic [31:0] mk_word(input logic [3:0] m, input logic wd,
        input logic [5:0] day, input logic pm, input logic [5:0] hr,
        input logic [6:0] mn, input logic [6:0] sc);
        return {m[3], wd, day, m[2], pm, hr, m[1], mn, m[0], sc};
    endfunction

    task automatic set_cal(input logic [6:0] s, input logic [6:0] mn,
        input logic [5:0] h, input logic pm, input logic [5:0] md, input logic [2:0] wd);
        cal_sec = s; cal_min = mn; cal_hour = h; cal_pm = pm;
        cal_mday = md; cal_wday = wd;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 word", alm_word, 32'h0);
        chk("R10 en/ie/wr_ok/flag/irq", {27'b0, alm_en, irq_en, wr_ok, alm_flag, irq}, 32'h0);

        // R5 handshake timing after reset
        slow_pulse();
        chk("R5 one slow pulse", wr_ok, 1'b0);
        slow_pulse();
        chk("R5 two slow pulses", wr_ok, 1'b1);
        ctl_write(1'b1, 1'b0);
        chk("R5 lock on enable", wr_ok, 1'b0);
        slow_pulse(); slow_pulse();
        chk("R5 stays locked while enabled", wr_ok, 1'b0);

        // R6 write ignored while locked
        word_write(32'h1234_5678);
        chk("R6 ignored while enabled", alm_word, 32'h0);
        ctl_write(1'b0, 1'b0);
        word_write(32'h1234_5678);
        chk("R6 ignored before delay", alm_word, 32'h0);
        slow_pulse();
        chk("R5 one pulse after disable", wr_ok, 1'b0);
        slow_pulse();
        chk("R5 two pulses after disable", wr_ok, 1'b1);
        word_write(32'hA5C3_3C5A);
        chk("R6 accepted when allowed", alm_word, 32'hA5C3_3C5A);

        // R1 R2 R3 sweep: all don't-care sets, both day modes, one field off at a time
        for (int m = 0; m < 16; m++) begin
            for (int wd = 0; wd < 2; wd++) begin
                for (int v = 0; v < 7; v++) begin
                    logic exp;
                    w = mk_word(4'(m), 1'(wd), (wd != 0) ? 6'h03 : 6'h28,
                                1'b1, 6'h11, 7'h32, 7'h45);
                    unlock();
                    word_write(w);
                    set_cal(7'h00, 7'h00, 6'h00, 1'b0, 6'h01, 3'd1);
                    tick_pulse(1'b0);   // disabled tick clears match history
                    clr_pulse();
                    ctl_write(1'b1, 1'b0);
                    set_cal(7'h45, 7'h32, 6'h11, 1'b1, 6'h28, 3'd3);
                    exp = 1'b1;
                    case (v)
                        1: begin cal_sec = 7'h46; exp = m[0]; end
                        2: begin cal_min = 7'h33; exp = m[1]; end
                        3: begin cal_hour = 6'h12; exp = m[2]; end
                        4: begin cal_pm = 1'b0; exp = m[2]; end
                        5: begin
                            if (wd != 0) cal_wday = 3'd4; else cal_mday = 6'h29;
                            exp = m[3];
                        end
                        6: begin
                            if (wd != 0) cal_mday = 6'h15; else cal_wday = 3'd5;
                            exp = 1'b1;
                        end
                        default: exp = 1'b1;
                    endcase
                    tick_pulse(1'b0);
                    chk($sformatf("R1 R2 R3 mask=%0d wd=%0d var=%0d", m, wd, v),
                        alm_flag, exp);
                end
            end
        end

        // R7 first-match only: only seconds compared, value 05
        unlock();
        word_write(mk_word(4'b1110, 1'b0, 6'h0, 1'b0, 6'h0, 7'h0, 7'h05));
        set_cal(7'h00, 7'h10, 6'h02, 1'b0, 6'h03, 3'd2);
        tick_pulse(1'b0);
        clr_pulse();
        ctl_write(1'b1, 1'b0);
        cal_sec = 7'h05; tick_pulse(1'b0);
        chk("R7 first match sets", alm_flag, 1'b1);
        clr_pulse();
        chk("R8 clear", alm_flag, 1'b0);
        tick_pulse(1'b0);
        chk("R7 held match does not refire", alm_flag, 1'b0);
        cal_sec = 7'h06; tick_pulse(1'b0);
        chk("R7 mismatch", alm_flag, 1'b0);
        cal_sec = 7'h05; tick_pulse(1'b0);
        chk("R7 new match sets", alm_flag, 1'b1);

        // R8 sticky across mismatching ticks, set beats clear
        cal_sec = 7'h06; tick_pulse(1'b0); tick_pulse(1'b0);
        chk("R8 sticky", alm_flag, 1'b1);
        cal_sec = 7'h05; tick_pulse(1'b1);
        chk("R8 set wins over clear", alm_flag, 1'b1);
        clr_pulse();
        chk("R8 clear after", alm_flag, 1'b0);

        // R9 interrupt gating
        cal_sec = 7'h06; tick_pulse(1'b0);
        cal_sec = 7'h05; tick_pulse(1'b0);
        chk("R9 flag set", alm_flag, 1'b1);
        chk("R9 no irq without ie", irq, 1'b0);
        ctl_write(1'b1, 1'b1);
        chk("R9 irq with ie", irq, 1'b1);
        clr_pulse();
        chk("R9 irq drops with flag", irq, 1'b0);

        // R4 disabled comparator never flags
        ctl_write(1'b0, 1'b1);
        cal_sec = 7'h06; tick_pulse(1'b0);
        cal_sec = 7'h05; tick_pulse(1'b0);
        chk("R4 no flag while disabled", alm_flag, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule